// File: doc/BRIEF.md
# Scan Shift Toggle Budget Monitor

This block observes a group of monitored scan flip-flop outputs while a scan chain shifts. At every shift cycle marked by a valid strobe, it compares the present sample of the group with the sample taken at the previous valid strobe. It counts the bits that differ and checks the total against a toggle budget supplied on an input port. The result is a transition count and a single flag that is high when the count does not exceed the budget. A sticky violation bit records whether any cycle has gone over the budget since the last clear.

The count is built in two stages. The monitored vector is cut into fixed-width partitions, and a small lookup table turns each partition into a partial count. A balanced adder tree then sums the partial counts. A synchronous clear drops the stored reference sample, so the next valid strobe only loads a new reference. The block is meant to sit next to a scan chain as a power-activity guard, or to be placed in a netlist that pattern generation must keep satisfied.

Top module: `scan_toggle_budget`

## Requirements
- R1: On a valid cycle that has a stored reference, the count equals the number of bit positions where `mon_i` differs from the sample taken at the previous valid cycle. Cycles without `vld_i` do not replace the reference.
- R2: The first valid cycle after reset or after a clear only stores the reference. It reports a count of 0, sets `ok_o` to 1 and leaves `viol_o` at 0.
- R3: `cnt_o` is ceil(log2(N_MON+1)) bits wide (6 bits for the default of 32 monitored signals). When all N_MON signals toggle, it reports exactly N_MON.
- R4: On each valid cycle, `ok_o` is 1 when the new count is less than or equal to `thresh_i` sampled in that same cycle, and 0 otherwise. A count equal to the threshold meets the budget.
- R5: `viol_o` goes to 1 on any valid cycle whose count exceeds the threshold. It stays at 1 through later passing cycles until a clear.
- R6: While `vld_i` is low and `clr_i` is low, `cnt_o`, `ok_o` and `viol_o` hold their values.
- R7: `clr_i` is synchronous and takes priority over `vld_i`. After a clear, `cnt_o` is 0, `ok_o` is 1 and `viol_o` is 0, and the reference is discarded.
- R8: While reset is asserted, `cnt_o` is 0, `ok_o` is 1 and `viol_o` is 0. Reset asserts asynchronously and is released after two clock edges.
- R9: Results for a valid or clear cycle appear on the outputs right after the clock edge that samples that cycle's inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of reference, count and sticky bit |
| vld_i | input | 1 | Marks a shift cycle whose sample is evaluated |
| mon_i | input | N_MON | Monitored scan flop outputs |
| thresh_i | input | CW | Toggle budget; a count at or below it passes |
| cnt_o | output | CW | Transition count of the last evaluated cycle |
| ok_o | output | 1 | Last evaluated count is within the budget |
| viol_o | output | 1 | Sticky: budget exceeded since the last clear |

## Verification
The sample, clear and threshold of a cycle all reach the outputs one register stage later. The bench therefore drives inputs on the falling edge and reads the outputs just after the next rising edge. There it compares them with a bench model that was updated for that same edge. Idle cycles are checked at the same point, so holding is seen cycle by cycle. The first valid cycle after a clear is checked in the cycle that follows the clear.

// File: rtl/stc_pkg.sv
package stc_pkg;

  // number of partitions needed to cover n bits in groups of w
  function automatic int part_count(input int n, input int w);
    return (n + w - 1) / w;
  endfunction

  // smallest power of two not below n (n >= 1)
  function automatic int pow2_ceil(input int n);
    int p;
    p = 1;
    while (p < n) p = p * 2;
    return p;
  endfunction

  // width able to hold values 0..n
  function automatic int count_width(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/stc_rst_sync.sv
module stc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/stc_ref_stage.sv
module stc_ref_stage #(
  parameter int N_MON = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             vld_i,
  input  logic [N_MON-1:0] mon_i,
  output logic [N_MON-1:0] tog_o,
  output logic             primed_o
);

  logic [N_MON-1:0] ref_q, ref_d;
  logic             primed_q, primed_d;
  logic             ref_en;

  assign ref_en = clr_i | vld_i;

  always_comb begin
    ref_d    = ref_q;
    primed_d = primed_q;
    if (clr_i) begin
      primed_d = 1'b0;
    end else if (vld_i) begin
      ref_d    = mon_i;
      primed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q    <= '0;
      primed_q <= 1'b0;
    end else if (ref_en) begin
      ref_q    <= ref_d;
      primed_q <= primed_d;
    end
  end

  // toggles are only meaningful once a reference is held
  assign tog_o    = primed_q ? (mon_i ^ ref_q) : '0;
  assign primed_o = primed_q;

  // R7: a clear leaves no reference behind
  p_clear_unprimes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_i) |-> !primed_q);

  // R2: an accepted sample always arms the reference for the next cycle
  p_valid_primes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(vld_i) && !$past(clr_i)) |-> primed_q);

endmodule

// File: rtl/stc_lut_popcnt.sv
module stc_lut_popcnt #(
  parameter  int W   = 4,
  localparam int PCW = $clog2(W + 1)
) (
  input  logic [W-1:0]   bits_i,
  output logic [PCW-1:0] cnt_o
);

  localparam int ENT = 1 << W;

  function automatic logic [ENT*PCW-1:0] build_table();
    logic [ENT*PCW-1:0] t;
    int c;
    t = '0;
    for (int e = 0; e < ENT; e++) begin
      c = 0;
      for (int b = 0; b < W; b++) c = c + ((e >> b) & 1);
      t[e*PCW +: PCW] = PCW'(c);
    end
    return t;
  endfunction

  localparam logic [ENT*PCW-1:0] TABLE = build_table();

  assign cnt_o = TABLE[int'(bits_i)*PCW +: PCW];

endmodule

// File: rtl/stc_adder_tree.sv
module stc_adder_tree #(
  parameter int NLEAF = 8,
  parameter int LW    = 3,
  parameter int CW    = 6
) (
  input  logic [NLEAF*LW-1:0] leaf_i,
  output logic [CW-1:0]       sum_o
);

  localparam int NPOW  = stc_pkg::pow2_ceil(NLEAF);
  localparam int NNODE = 2 * NPOW - 1;

  logic [CW-1:0] node [NNODE];

  // leaves sit at the bottom of a heap-ordered array; unused ones are zero
  for (genvar l = 0; l < NPOW; l++) begin : g_leaf
    if (l < NLEAF) begin : g_real
      assign node[NPOW-1+l] = CW'(leaf_i[l*LW +: LW]);
    end else begin : g_pad
      assign node[NPOW-1+l] = '0;
    end
  end

  for (genvar n = 0; n < NPOW - 1; n++) begin : g_node
    assign node[n] = node[2*n+1] + node[2*n+2];
  end

  assign sum_o = node[0];

endmodule

// File: rtl/scan_toggle_budget.sv
module scan_toggle_budget #(
  parameter  int N_MON  = 32,
  parameter  int PART_W = 4,
  localparam int CW     = stc_pkg::count_width(N_MON)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             vld_i,
  input  logic [N_MON-1:0] mon_i,
  input  logic [CW-1:0]    thresh_i,
  output logic [CW-1:0]    cnt_o,
  output logic             ok_o,
  output logic             viol_o
);

  localparam int NPART = stc_pkg::part_count(N_MON, PART_W);
  localparam int PADW  = NPART * PART_W;
  localparam int PCW   = $clog2(PART_W + 1);

  logic             rst_sync_n;
  logic [N_MON-1:0] tog;
  logic             primed;
  logic [PADW-1:0]  tog_pad;
  logic [NPART*PCW-1:0] part_cnt;
  logic [CW-1:0]    sum;
  logic             sum_ok;

  stc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  stc_ref_stage #(.N_MON(N_MON)) u_ref (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr_i    (clr_i),
    .vld_i    (vld_i),
    .mon_i    (mon_i),
    .tog_o    (tog),
    .primed_o (primed)
  );

  // pad the toggle vector to whole partitions
  if (PADW > N_MON) begin : g_pad
    assign tog_pad = {{(PADW-N_MON){1'b0}}, tog};
  end else begin : g_nopad
    assign tog_pad = tog;
  end

  for (genvar p = 0; p < NPART; p++) begin : g_part
    stc_lut_popcnt #(.W(PART_W)) u_lut (
      .bits_i (tog_pad[p*PART_W +: PART_W]),
      .cnt_o  (part_cnt[p*PCW +: PCW])
    );
  end

  stc_adder_tree #(.NLEAF(NPART), .LW(PCW), .CW(CW)) u_tree (
    .leaf_i (part_cnt),
    .sum_o  (sum)
  );

  assign sum_ok = (sum <= thresh_i);

  // result registers
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ok_q, ok_d;
  logic          viol_q, viol_d;
  logic          res_en;

  assign res_en = clr_i | vld_i;

  always_comb begin
    cnt_d  = cnt_q;
    ok_d   = ok_q;
    viol_d = viol_q;
    if (clr_i) begin
      cnt_d  = '0;
      ok_d   = 1'b1;
      viol_d = 1'b0;
    end else if (vld_i) begin
      cnt_d  = sum;
      ok_d   = sum_ok;
      viol_d = viol_q | ~sum_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cnt_q  <= '0;
      ok_q   <= 1'b1;
      viol_q <= 1'b0;
    end else if (res_en) begin
      cnt_q  <= cnt_d;
      ok_q   <= ok_d;
      viol_q <= viol_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign ok_o   = ok_q;
  assign viol_o = viol_q;

  // R3: count never exceeds the number of monitored signals
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cnt_o <= CW'(N_MON));

  // R2: an unprimed valid cycle reports zero toggles
  p_first_zero_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(vld_i) && !$past(clr_i) && !$past(primed)) |-> (cnt_o == '0 && ok_o));

  // R4: flag agrees with the count and the threshold of the sampled cycle
  p_flag_vs_thresh_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(vld_i) && !$past(clr_i)) |-> (ok_o == (cnt_o <= $past(thresh_i))));

  // R5: sticky bit stays until a clear
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(viol_o) && !$past(clr_i)) |-> viol_o);

  // R5: a failing cycle always leaves the sticky bit set
  p_fail_sets_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ok_o |-> viol_o);

  // R6: idle cycles hold every result
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!$past(vld_i) && !$past(clr_i)) |-> ($stable(cnt_o) && $stable(ok_o) && $stable(viol_o)));

  // R7: a clear restores the idle result values
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(clr_i) |-> (cnt_o == '0 && ok_o && !viol_o));

endmodule

// File: tb/scan_toggle_budget_test.sv
module scan_toggle_budget_test;

  localparam int N  = 32;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr_i = 1'b0;
  logic          vld_i = 1'b0;
  logic [N-1:0]  mon_i = '0;
  logic [CW-1:0] thresh_i = '0;
  logic [CW-1:0] cnt_o;
  logic          ok_o;
  logic          viol_o;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [N-1:0]  m_ref = '0;
  bit            m_primed = 0;
  int            m_cnt = 0;
  bit            m_ok = 1;
  bit            m_viol = 0;

  always #4 clk = ~clk;  // 125 MHz

  scan_toggle_budget #(.N_MON(N), .PART_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .vld_i(vld_i),
    .mon_i(mon_i), .thresh_i(thresh_i),
    .cnt_o(cnt_o), .ok_o(ok_o), .viol_o(viol_o)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int toggles(input logic [N-1:0] a, input logic [N-1:0] b);
    int c = 0;
    for (int i = 0; i < N; i++) if (a[i] != b[i]) c++;
    return c;
  endfunction

  task automatic check_all(input string tag);
    check(tag, "cnt_o", int'(cnt_o), m_cnt);
    check(tag, "ok_o", int'(ok_o), int'(m_ok));
    check(tag, "viol_o", int'(viol_o), int'(m_viol));
  endtask

  // one cycle: drive on falling edge, update model at rising edge, sample after it (R9)
  task automatic cyc(input string tag, input bit v, input logic [N-1:0] m,
                     input int th, input bit c);
    @(negedge clk);
    vld_i = v; mon_i = m; thresh_i = CW'(th); clr_i = c;
    @(posedge clk);
    if (c) begin
      m_cnt = 0; m_ok = 1; m_viol = 0; m_primed = 0;
    end else if (v) begin
      m_cnt   = m_primed ? toggles(m, m_ref) : 0;
      m_ok    = (m_cnt <= th);
      m_viol  = m_viol | !m_ok;
      m_ref   = m;
      m_primed = 1;
    end
    #1;
    check_all(tag);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] a;
    void'($urandom(32'h5eed_0042));
    a = 32'hA5C3_0F96;

    // R8: reset state, held in reset
    repeat (3) @(posedge clk);
    #1;
    check_all("R8");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check_all("R8");

    // R2: first valid cycle only stores the reference
    cyc("R2", 1, a, 0, 0);
    // R3: every bit toggles, count is N; R4/R5: over a threshold of 31
    cyc("R3", 1, ~a, 31, 0);
    // R4: equality passes; R5: sticky bit stays set
    cyc("R4", 1, a, 32, 0);
    // R6: idle cycles with changing inputs hold results
    for (int i = 0; i < 3; i++) cyc("R6", 0, $urandom(), 0, 0);
    // R1: idle samples did not replace the reference; one bit differs
    cyc("R1", 1, a ^ 32'h1, 1, 0);
    cyc("R4", 1, a ^ 32'h7, 1, 0);
    // R7: clear with valid high wins; next valid only stores
    cyc("R7", 1, 32'hFFFF_0000, 0, 1);
    cyc("R7", 1, 32'h0000_0000, 0, 0);
    cyc("R1", 1, 32'h0000_00F0, 4, 0);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      bit v, c;
      logic [N-1:0] m;
      v = ($urandom_range(0, 3) != 0);
      c = ($urandom_range(0, 39) == 0);
      m = $urandom();
      if ($urandom_range(0, 3) == 0) m = m_ref ^ (32'h1 << $urandom_range(0, 31));
      cyc("R1", v, m, $urandom_range(8, 24), c);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule